// File: doc/BRIEF.md
# Tower-Field Affine-Inverse Substitution Box

This block is an 8-bit substitution box with no clock and no state. Each input byte is treated as an element of GF(2^8) built on the irreducible polynomial t(v) = v^8 + v^6 + v^5 + v^4 + v^2 + v + 1. The block finds its multiplicative inverse and passes that inverse through a fixed affine map over GF(2). Zero has no inverse, so it is carried through as zero.

There is no lookup table. The byte is first moved into a nested tower representation, GF(((2^2)^2)^2). The inverse is then built from XOR and AND logic in the subfields, and a second basis change brings it back into the polynomial basis. Both basis-change matrices and the two tower constants are derived during elaboration from the field polynomial parameter, so no hand-typed matrix can drift out of step with the polynomial.

The block is meant to be used as a combinational cell inside a cipher round, and the result settles in the same cycle as the input.

Top module: `sbox_top`

## Requirements
- R1: For every input x, sboxOut equals A(x^-1), with the inverse taken in GF(2^8) modulo t(v) (reduction value 0x177) and the result settling in the same cycle as the input.
- R2: The value fed to the affine stage is the field inverse: multiplied by the input modulo t(v), it gives 1 for every nonzero input.
- R3: The tower-field inverter returns an element whose tower product with its input is 1 for every nonzero input, and this holds at both the GF(2^4) and the GF(2^8) levels.
- R4: An input of 0x00 yields an inverse of 0x00, so sboxOut equals the affine constant, which is 0x63 by default.
- R5: The mapping is a bijection, so the 256 inputs give 256 distinct outputs.
- R6: Output bit i is the parity of the inverse bits i, i+4, i+5, i+6 and i+7 (indices taken mod 8), XORed with bit i of the constant 0x63. For input 0x01 this gives 0x7C.
- R7: The output depends only on the current input: applying the same byte again, in any order, gives the same output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sboxIn | input | 8 | Byte to substitute, polynomial basis of t(v) |
| sboxOut | output | 8 | Substituted byte |

## Verification
Two functions can act on the same input: the zero-handling of the inverter and the affine constant injection. Input 0x00 is the case where both decide the output alone. That input is driven during the bench reset and again inside the exhaustive sweep, and each time the output is judged against the bare constant. The bench also compares all 256 inputs against a reference inverse. That reference finds the inverse by exhaustive multiplication modulo t(v), and the affine rule is written out bit by bit. The outputs of the sweep are then recorded and checked for repeats.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

  // GF(4): basis {w,1}, w^2 = w + 1
  function automatic logic [1:0] gf4Mul(input logic [1:0] a, input logic [1:0] b);
    logic hh;
    hh = a[1] & b[1];
    return {hh ^ (a[1] & b[0]) ^ (a[0] & b[1]), hh ^ (a[0] & b[0])};
  endfunction

  function automatic logic [1:0] gf4Sq(input logic [1:0] a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  // GF(16) over GF(4): z^2 = z + n
  function automatic logic [3:0] gf16Mul(input logic [3:0] a, input logic [3:0] b,
                                         input logic [1:0] n);
    logic [1:0] hh, hi, lo;
    hh = gf4Mul(a[3:2], b[3:2]);
    hi = hh ^ gf4Mul(a[3:2], b[1:0]) ^ gf4Mul(a[1:0], b[3:2]);
    lo = gf4Mul(hh, n) ^ gf4Mul(a[1:0], b[1:0]);
    return {hi, lo};
  endfunction

  // GF(256) over GF(16): y^2 = y + m
  function automatic logic [7:0] towerMul(input logic [7:0] a, input logic [7:0] b,
                                          input logic [1:0] n, input logic [3:0] m);
    logic [3:0] hh, hi, lo;
    hh = gf16Mul(a[7:4], b[7:4], n);
    hi = hh ^ gf16Mul(a[7:4], b[3:0], n) ^ gf16Mul(a[3:0], b[7:4], n);
    lo = gf16Mul(hh, m, n) ^ gf16Mul(a[3:0], b[3:0], n);
    return {hi, lo};
  endfunction

  // Polynomial-basis product modulo v^8 + poly
  function automatic logic [7:0] polyMul(input logic [7:0] a, input logic [7:0] b,
                                         input logic [7:0] poly);
    logic [7:0] acc;
    acc = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      acc = {acc[6:0], 1'b0} ^ (acc[7] ? poly : 8'h00);
      if (b[i]) acc = acc ^ a;
    end
    return acc;
  endfunction

  // Smallest n making z^2 + z + n irreducible over GF(4)
  function automatic logic [1:0] findGf16Const();
    logic [1:0] res;
    logic found, ok;
    res = 2'd0;
    found = 1'b0;
    for (int c = 1; c < 4; c++) begin
      ok = 1'b1;
      for (int z = 0; z < 4; z++)
        if ((gf4Mul(2'(z), 2'(z)) ^ 2'(z) ^ 2'(c)) == 2'd0) ok = 1'b0;
      if (ok && !found) begin
        res = 2'(c);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  // Smallest m making y^2 + y + m irreducible over GF(16)
  function automatic logic [3:0] findGf256Const(input logic [1:0] n);
    logic [3:0] res;
    logic found, ok;
    res = 4'd0;
    found = 1'b0;
    for (int c = 1; c < 16; c++) begin
      ok = 1'b1;
      for (int y = 0; y < 16; y++)
        if ((gf16Mul(4'(y), 4'(y), n) ^ 4'(y) ^ 4'(c)) == 4'd0) ok = 1'b0;
      if (ok && !found) begin
        res = 4'(c);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  // Value of the field polynomial at a tower element (Horner)
  function automatic logic [7:0] evalFieldPoly(input logic [7:0] beta, input logic [7:0] poly,
                                               input logic [1:0] n, input logic [3:0] m);
    logic [7:0] acc;
    acc = 8'h01;
    for (int k = 7; k >= 0; k--)
      acc = towerMul(acc, beta, n, m) ^ {7'd0, poly[k]};
    return acc;
  endfunction

  function automatic logic [7:0] findRoot(input logic [7:0] poly, input logic [1:0] n,
                                          input logic [3:0] m);
    logic [7:0] res;
    logic found;
    res = 8'h00;
    found = 1'b0;
    for (int b = 2; b < 256; b++)
      if (!found && evalFieldPoly(8'(b), poly, n, m) == 8'h00) begin
        res = 8'(b);
        found = 1'b1;
      end
    return res;
  endfunction

  // Column j of the matrix is the image of basis vector j
  function automatic logic [63:0] powerColumns(input logic [7:0] root, input logic [1:0] n,
                                               input logic [3:0] m);
    logic [63:0] cols;
    logic [7:0] p;
    p = 8'h01;
    cols = 64'd0;
    for (int j = 0; j < 8; j++) begin
      cols[8*j +: 8] = p;
      p = towerMul(p, root, n, m);
    end
    return cols;
  endfunction

  function automatic logic [7:0] applyColumns(input logic [63:0] cols, input logic [7:0] x);
    logic [7:0] acc;
    acc = 8'h00;
    for (int j = 0; j < 8; j++)
      if (x[j]) acc = acc ^ cols[8*j +: 8];
    return acc;
  endfunction

  function automatic logic [63:0] invertColumns(input logic [63:0] cols);
    logic [63:0] res;
    res = 64'd0;
    for (int j = 0; j < 8; j++)
      for (int p = 0; p < 256; p++)
        if (applyColumns(cols, 8'(p)) == (8'h01 << j)) res[8*j +: 8] = 8'(p);
    return res;
  endfunction

endpackage

// File: rtl/sbox_basis_map.sv
module sbox_basis_map #(
  parameter logic [63:0] COLS = 64'h8040201008040201
) (
  input  logic [7:0] dIn,
  output logic [7:0] dOut
);
  logic [7:0] partSum [0:8];

  assign partSum[0] = 8'h00;
  for (genvar g = 0; g < 8; g++) begin : gCol
    assign partSum[g+1] = partSum[g] ^ (COLS[8*g +: 8] & {8{dIn[g]}});
  end
  assign dOut = partSum[8];
endmodule

// File: rtl/sbox_gf16_inv.sv
module sbox_gf16_inv
  import sbox_pkg::*;
#(
  parameter logic [1:0] NCONST = 2'd2
) (
  input  logic [3:0] dIn,
  output logic [3:0] dOut
);
  logic [1:0] hiIn, loIn, norm, normInv;

  assign hiIn    = dIn[3:2];
  assign loIn    = dIn[1:0];
  assign norm    = gf4Mul(gf4Sq(hiIn), NCONST) ^ gf4Mul(hiIn, loIn) ^ gf4Sq(loIn);
  assign normInv = gf4Sq(norm);
  assign dOut    = {gf4Mul(normInv, hiIn), gf4Mul(normInv, hiIn ^ loIn)};

  always_comb begin
    assert_gf16_product_R3: assert (dIn == 4'd0 || gf16Mul(dIn, dOut, NCONST) == 4'd1)
      else $error("R3: GF(16) inverse of %h gave %h", dIn, dOut);
  end
endmodule

// File: rtl/sbox_tower_inv.sv
module sbox_tower_inv
  import sbox_pkg::*;
#(
  parameter logic [1:0] NCONST = 2'd2,
  parameter logic [3:0] MCONST = 4'd8
) (
  input  logic [7:0] dIn,
  output logic [7:0] dOut
);
  logic [3:0] hiIn, loIn, norm, normInv;

  assign hiIn = dIn[7:4];
  assign loIn = dIn[3:0];
  assign norm = gf16Mul(gf16Mul(hiIn, hiIn, NCONST), MCONST, NCONST)
              ^ gf16Mul(hiIn, loIn, NCONST)
              ^ gf16Mul(loIn, loIn, NCONST);

  sbox_gf16_inv #(.NCONST(NCONST)) u_normInv (
    .dIn (norm),
    .dOut(normInv)
  );

  assign dOut = {gf16Mul(normInv, hiIn, NCONST), gf16Mul(normInv, hiIn ^ loIn, NCONST)};

  always_comb begin
    assert_tower_product_R3: assert (dIn == 8'd0 || towerMul(dIn, dOut, NCONST, MCONST) == 8'd1)
      else $error("R3: tower inverse of %h gave %h", dIn, dOut);
    assert_tower_zero_R4: assert (dIn != 8'd0 || dOut == 8'd0)
      else $error("R4: tower inverse of zero gave %h", dOut);
  end
endmodule

// File: rtl/sbox_affine.sv
module sbox_affine #(
  parameter logic [63:0] ROWS   = 64'hF87C3E1F8FC7E3F1,
  parameter logic [7:0]  ACONST = 8'h63
) (
  input  logic [7:0] dIn,
  output logic [7:0] dOut
);
  for (genvar g = 0; g < 8; g++) begin : gRow
    assign dOut[g] = (^(ROWS[8*g +: 8] & dIn)) ^ ACONST[g];
  end
endmodule

// File: rtl/sbox_top.sv
module sbox_top
  import sbox_pkg::*;
#(
  parameter logic [7:0]  FIELD_POLY = 8'h77,
  parameter logic [63:0] AFF_ROWS   = 64'hF87C3E1F8FC7E3F1,
  parameter logic [7:0]  AFF_CONST  = 8'h63
) (
  input  logic [7:0] sboxIn,
  output logic [7:0] sboxOut
);
  localparam logic [1:0]  NCONST   = findGf16Const();
  localparam logic [3:0]  MCONST   = findGf256Const(NCONST);
  localparam logic [7:0]  ROOT     = findRoot(FIELD_POLY, NCONST, MCONST);
  localparam logic [63:0] TO_TOWER = powerColumns(ROOT, NCONST, MCONST);
  localparam logic [63:0] TO_POLY  = invertColumns(TO_TOWER);

  logic [7:0] towerIn, towerInv, polyInv;

  sbox_basis_map #(.COLS(TO_TOWER)) u_toTower (
    .dIn (sboxIn),
    .dOut(towerIn)
  );

  sbox_tower_inv #(.NCONST(NCONST), .MCONST(MCONST)) u_inv (
    .dIn (towerIn),
    .dOut(towerInv)
  );

  sbox_basis_map #(.COLS(TO_POLY)) u_toPoly (
    .dIn (towerInv),
    .dOut(polyInv)
  );

  sbox_affine #(.ROWS(AFF_ROWS), .ACONST(AFF_CONST)) u_affine (
    .dIn (polyInv),
    .dOut(sboxOut)
  );

  always_comb begin
    assert_field_inverse_R2: assert (sboxIn == 8'd0 || polyMul(sboxIn, polyInv, FIELD_POLY) == 8'd1)
      else $error("R2: inverse of %h gave %h", sboxIn, polyInv);
    assert_zero_constant_R4: assert (sboxIn != 8'd0 || sboxOut == AFF_CONST)
      else $error("R4: zero input gave %h", sboxOut);
  end
endmodule

// File: tb/sbox_top_tb.sv
`timescale 1ns/1ps
module sbox_top_tb;
  typedef struct { logic [7:0] din; logic [7:0] expOut; logic inSweep; string req; } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] sboxIn = 8'h00;
  logic [7:0] sboxOut;
  int nChecked = 0;
  int nFailed = 0;
  bit finished = 1'b0;
  item_t scoreQ[$];
  bit seen [0:255];

  always #2.5 clk = ~clk;

  sbox_top u_dut (.sboxIn(sboxIn), .sboxOut(sboxOut));

  function automatic logic [7:0] refMul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] prod;
    prod = 16'd0;
    for (int i = 0; i < 8; i++) if (b[i]) prod = prod ^ (16'(a) << i);
    for (int k = 15; k >= 8; k--) if (prod[k]) prod = prod ^ (16'h0177 << (k - 8));
    return prod[7:0];
  endfunction

  function automatic logic [7:0] refInv(input logic [7:0] a);
    logic [7:0] r;
    r = 8'h00;
    for (int y = 1; y < 256; y++) if (refMul(a, 8'(y)) == 8'h01) r = 8'(y);
    return r;
  endfunction

  function automatic logic [7:0] refAffine(input logic [7:0] a);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = a[i] ^ a[(i+4)%8] ^ a[(i+5)%8] ^ a[(i+6)%8] ^ a[(i+7)%8] ^ 8'h63 >> i & 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] refSbox(input logic [7:0] a);
    return refAffine(refInv(a));
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp, input logic [7:0] din);
    nChecked++;
    if (act !== exp) begin
      nFailed++;
      $display("FAIL %s: input %h actual %h expected %h", req, din, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] v, input bit sweep, input string req);
    item_t it;
    @(posedge clk);
    sboxIn <= v;
    it.din = v; it.expOut = refSbox(v); it.inSweep = sweep; it.req = req;
    scoreQ.push_back(it);
  endtask

  // monitor: compare half a cycle after each drive
  always @(negedge clk) begin
    if (scoreQ.size() > 0) begin
      item_t it;
      it = scoreQ.pop_front();
      check(it.req, sboxOut, it.expOut, it.din);
      if (it.inSweep) seen[sboxOut] = 1'b1;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      nFailed++;
      nChecked++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nFailed);
      $finish;
    end
  end

  initial begin
    int distinct;
    for (int i = 0; i < 256; i++) seen[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R4 reset-state zero", sboxOut, 8'h63, 8'h00); // R4
    rstN = 1'b1;
    // R6 known value: inverse of 1 is 1 -> 0x7C
    drive(8'h01, 1'b0, "R6");
    drive(8'h00, 1'b0, "R4");
    // R1 exhaustive sweep, also feeds the R5 bijection record
    for (int i = 0; i < 256; i++) drive(8'(i), 1'b1, "R1");
    // R7 repeats in a different order: descending, walking ones, alternating
    for (int i = 255; i >= 0; i -= 17) drive(8'(i), 1'b0, "R7");
    for (int i = 0; i < 8; i++) drive(8'h01 << i, 1'b0, "R7");
    drive(8'hAA, 1'b0, "R7"); drive(8'h55, 1'b0, "R7"); drive(8'hAA, 1'b0, "R7");
    drive(8'hFF, 1'b0, "R2"); drive(8'h02, 1'b0, "R3");
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 constant for 0x01", refSbox(8'h01), 8'h7C, 8'h01);
    distinct = 0;
    for (int i = 0; i < 256; i++) if (seen[i]) distinct++;
    nChecked++;
    if (distinct != 256) begin
      nFailed++;
      $display("FAIL R5: distinct outputs actual %0d expected 256", distinct);
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nFailed);
    $finish;
  end
endmodule